// File: doc/BRIEF.md
# Tiled Framebuffer Pixel Address Generator

This block turns a rectangle in screen coordinates into the sequence of pixel indices that a writer must touch in a framebuffer. After a start pulse it walks the rectangle row by row, left to right, and emits one pixel index per accepted transfer on a valid/ready stream. The index is the byte address of the pixel divided by the pixel size.

The buffer may use one of four memory layouts: plain linear rows, a wide tile of 512 bytes by 8 rows, a narrow tile of 128 bytes by 32 rows that stores 16-byte units column by column, or a 4 KiB tile made of 16-byte by 4-row subtiles whose order is permuted. For the two older tiled layouts an optional swizzle folds address bits 9, 10 and 11 into bit 6. A configuration that cannot be served is refused with a one-cycle error pulse. The memory writes themselves are done elsewhere.

Top module: `tile_addr_gen`

## Requirements
- R1: While reset is held and after its release, out_valid, done and cfg_err are 0 until a start is accepted.
- R2: A start sampled while idle latches the configuration; the first index is valid two clock edges after the start edge, and exactly rect_w*rect_h indices follow in row-major order from (rect_x, rect_y).
- R3: Linear layout (layout=0): byte address = y*stride + x*pixel_bytes.
- R4: Wide tile layout (layout=1): tiles are 512 bytes by 8 rows, 4096 bytes each, numbered left to right then downward with stride/512 per tile row; inside a tile bytes run row by row.
- R5: Narrow tile layout (layout=2): 16-byte units form tiles of 8 units by 32 rows, units inside a tile run column by column (unit offset = ux_in_tile*32 + y mod 32); byte address = unit_number*16 + byte_x mod 16, tiles numbered with stride/128 per tile row.
- R6: 4 KiB subtile layout (layout=3): tile base = (y/32)*stride*32 + 4096*(byte_x/128); subtile number s = ((y mod 32)/4)*8 + (byte_x mod 128)/16 is remapped by swapping the groups 4..7 and 8..11 within every block of 16; address = base + remapped*64 + (y mod 4)*16 + byte_x mod 16.
- R7: swz_mode codes: 0 none, 1 bit6^=bit9, 2 bit6^=bit9^bit10, 3 bit6^=bit9^bit11, 4 bit6^=bit9^bit10^bit11; applied to layouts 1 and 2 only, a supported code has no effect on linear indices.
- R8: cfg_err pulses for one cycle, one edge after the start edge, with no index and no done, when swz_mode is 5..7, when layout=3 with swz_mode not 0, or when stride is not a multiple of 512 (layout 1) or 128 (layouts 2 and 3).
- R9: While out_valid is 1 and out_ready is 0, out_valid and out_index hold their values.
- R10: done pulses for one cycle in the cycle after the last index is accepted, with out_valid then 0; a rectangle with zero width or height gives done one edge after the start edge and no index.
- R11: A start pulse while a rectangle is in progress is ignored; the running stream is unchanged.
- R12: bpp32=1 selects 4-byte pixels, bpp32=0 2-byte pixels; pixel_bytes scales x and divides the final byte address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a rectangle when idle |
| rect_x | input | COORD_W | Left pixel column |
| rect_y | input | COORD_W | Top pixel row |
| rect_w | input | COORD_W | Width in pixels |
| rect_h | input | COORD_W | Height in pixels |
| stride | input | STRIDE_W | Bytes per buffer row |
| layout | input | 2 | Memory layout select |
| swz_mode | input | 3 | Bit-6 swizzle select |
| bpp32 | input | 1 | 1: 32 bpp, 0: 16 bpp |
| out_valid | output | 1 | Index stream valid |
| out_ready | input | 1 | Index stream ready |
| out_index | output | ADDR_W | Pixel index |
| done | output | 1 | Rectangle finished pulse |
| cfg_err | output | 1 | Refused configuration pulse |

## Verification
A wrong walk counter shows as a wrong or repeated index on the very next accepted transfer, since each transfer is compared against an independently computed address. A mistake in a layout term usually appears only when the rectangle crosses a tile, unit or subtile edge, so the rectangles are placed to straddle those edges. A stuck end-of-rectangle flag shows either as a missing done in the cycle after the final transfer or as extra indices after it, both observed within one clock.

// File: rtl/tag_pkg.sv
package tag_pkg;

    typedef enum logic [1:0] {
        LAY_LINEAR = 2'd0,
        LAY_WIDE   = 2'd1,
        LAY_NARROW = 2'd2,
        LAY_SUB4K  = 2'd3
    } layout_e;

    // Which of address bits 9, 10, 11 feed bit 6 (bit 0 of result = bit 9).
    function automatic logic [2:0] swz_taps(input logic [2:0] mode);
        case (mode)
            3'd1:    return 3'b001;
            3'd2:    return 3'b011;
            3'd3:    return 3'b101;
            3'd4:    return 3'b111;
            default: return 3'b000;
        endcase
    endfunction

    function automatic logic swz_legal(input logic [2:0] mode);
        return mode <= 3'd4;
    endfunction

    // Groups 4..7 and 8..11 of each 16 trade places: swap bits 2 and 3.
    function automatic logic [5:0] subtile_swap(input logic [5:0] s);
        return {s[5:4], s[2], s[3], s[1:0]};
    endfunction

endpackage

// File: rtl/tag_layout_map.sv
module tag_layout_map #(
    parameter int COORD_W  = 17,
    parameter int STRIDE_W = 16,
    parameter int ADDR_W   = 32
) (
    input  logic [1:0]          layout,
    input  logic                bpp32,
    input  logic [STRIDE_W-1:0] stride,
    input  logic [COORD_W-1:0]  px,
    input  logic [COORD_W-1:0]  py,
    output logic [ADDR_W-1:0]   byte_addr
);
    import tag_pkg::*;

    logic [ADDR_W-1:0] bx, ya, sa;
    logic [ADDR_W-1:0] lin_a, wide_a, base32, narrow_a, sub_a;
    logic [5:0]        sub_raw, sub_map;

    always_comb begin
        bx = ADDR_W'(px) << (bpp32 ? 2 : 1);
        ya = ADDR_W'(py);
        sa = ADDR_W'(stride);

        lin_a  = ya * sa + bx;

        wide_a = (((ya >> 3) * sa) << 3) + ((bx >> 9) << 12)
               + ((ya & ADDR_W'(7)) << 9) + (bx & ADDR_W'(511));

        base32 = (((ya >> 5) * sa) << 5) + ((bx >> 7) << 12);

        narrow_a = base32 + (((bx >> 4) & ADDR_W'(7)) << 9)
                 + ((ya & ADDR_W'(31)) << 4) + (bx & ADDR_W'(15));

        sub_raw = {ya[4:2], bx[6:4]};
        sub_map = subtile_swap(sub_raw);
        sub_a   = base32 + (ADDR_W'(sub_map) << 6)
                + ((ya & ADDR_W'(3)) << 4) + (bx & ADDR_W'(15));

        case (layout_e'(layout))
            LAY_WIDE:   byte_addr = wide_a;
            LAY_NARROW: byte_addr = narrow_a;
            LAY_SUB4K:  byte_addr = sub_a;
            default:    byte_addr = lin_a;
        endcase
    end

endmodule

// File: rtl/tag_bit6_swz.sv
module tag_bit6_swz #(
    parameter int ADDR_W = 32
) (
    input  logic [2:0]        mode,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    import tag_pkg::*;

    localparam int N_TAPS   = 3;
    localparam int TAP_BASE = 9;

    logic [2:0]        taps;
    logic [N_TAPS-1:0] hit;

    assign taps = swz_taps(mode);

    for (genvar b = 0; b < N_TAPS; b++) begin : g_tap
        assign hit[b] = taps[b] & addr_in[TAP_BASE + b];
    end

    assign addr_out = {addr_in[ADDR_W-1:7], addr_in[6] ^ (^hit), addr_in[5:0]};

endmodule

// File: rtl/tile_addr_gen.sv
module tile_addr_gen #(
    parameter int COORD_W  = 16,
    parameter int STRIDE_W = 16,
    parameter int ADDR_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [COORD_W-1:0]  rect_x,
    input  logic [COORD_W-1:0]  rect_y,
    input  logic [COORD_W-1:0]  rect_w,
    input  logic [COORD_W-1:0]  rect_h,
    input  logic [STRIDE_W-1:0] stride,
    input  logic [1:0]          layout,
    input  logic [2:0]          swz_mode,
    input  logic                bpp32,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [ADDR_W-1:0]   out_index,
    output logic                done,
    output logic                cfg_err
);
    import tag_pkg::*;

    localparam int PW = COORD_W + 1;

    typedef struct packed {
        logic                active;
        logic [PW-1:0]       cx;
        logic [PW-1:0]       cy;
        logic [PW-1:0]       x_first;
        logic [PW-1:0]       x_last;
        logic [PW-1:0]       y_last;
        logic [1:0]          lay;
        logic [2:0]          swz;
        logic                b32;
        logic [STRIDE_W-1:0] strd;
        logic                ov;
        logic [ADDR_W-1:0]   oidx;
        logic                olast;
        logic                done;
        logic                err;
    } st_t;

    st_t q, d;

    logic [ADDR_W-1:0] raw_addr, swz_addr, pix_idx;
    logic [2:0]        eff_swz;
    logic              at_last, cfg_ok, stride_ok, empty;

    tag_layout_map #(
        .COORD_W (PW),
        .STRIDE_W(STRIDE_W),
        .ADDR_W  (ADDR_W)
    ) i_map (
        .layout   (q.lay),
        .bpp32    (q.b32),
        .stride   (q.strd),
        .px       (q.cx),
        .py       (q.cy),
        .byte_addr(raw_addr)
    );

    assign eff_swz = (layout_e'(q.lay) == LAY_WIDE || layout_e'(q.lay) == LAY_NARROW)
                   ? q.swz : 3'd0;

    tag_bit6_swz #(.ADDR_W(ADDR_W)) i_swz (
        .mode    (eff_swz),
        .addr_in (raw_addr),
        .addr_out(swz_addr)
    );

    assign pix_idx = swz_addr >> (q.b32 ? 2 : 1);
    assign at_last = (q.cx == q.x_last) && (q.cy == q.y_last);

    always_comb begin
        case (layout_e'(layout))
            LAY_WIDE:   stride_ok = (stride & STRIDE_W'(511)) == '0;
            LAY_NARROW,
            LAY_SUB4K:  stride_ok = (stride & STRIDE_W'(127)) == '0;
            default:    stride_ok = 1'b1;
        endcase
        cfg_ok = stride_ok && swz_legal(swz_mode)
              && !(layout_e'(layout) == LAY_SUB4K && swz_mode != 3'd0);
        empty  = (rect_w == '0) || (rect_h == '0);
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;

        // Consumer takes the held index.
        if (q.ov && out_ready) begin
            d.ov = 1'b0;
            if (q.olast) begin
                d.done = 1'b1;
            end
        end

        // Refill the output register while walking.
        if (q.active && (!q.ov || out_ready)) begin
            d.ov    = 1'b1;
            d.oidx  = pix_idx;
            d.olast = at_last;
            if (at_last) begin
                d.active = 1'b0;
            end else if (q.cx == q.x_last) begin
                d.cx = q.x_first;
                d.cy = q.cy + PW'(1);
            end else begin
                d.cx = q.cx + PW'(1);
            end
        end

        // Accept a new rectangle only when fully idle.
        if (start && !q.active && !q.ov) begin
            d.lay  = layout;
            d.swz  = swz_mode;
            d.b32  = bpp32;
            d.strd = stride;
            if (!cfg_ok) begin
                d.err = 1'b1;
            end else if (empty) begin
                d.done = 1'b1;
            end else begin
                d.active  = 1'b1;
                d.cx      = PW'(rect_x);
                d.cy      = PW'(rect_y);
                d.x_first = PW'(rect_x);
                d.x_last  = PW'(rect_x) + PW'(rect_w) - PW'(1);
                d.y_last  = PW'(rect_y) + PW'(rect_h) - PW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign out_valid = q.ov;
    assign out_index = q.oidx;
    assign done      = q.done;
    assign cfg_err   = q.err;

endmodule

// File: rtl/tile_addr_gen_chk.sv
module tile_addr_gen_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ADDR_W-1:0] out_index,
    input logic              done,
    input logic              cfg_err
);
    // R9: a stalled index stays put
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_index));

    // R10: done never overlaps a pending index
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid);

    // R10: done follows either a final transfer or an empty start
    a_r10_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(out_valid && out_ready) || $past(start)));

    // R8: a refused start produces nothing else
    a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !out_valid && !done);
endmodule

bind tile_addr_gen tile_addr_gen_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_index(out_index),
    .done     (done),
    .cfg_err  (cfg_err)
);

// File: tb/test_tile_addr_gen.sv
module test_tile_addr_gen;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 16;
    localparam int SW = 16;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] rect_x = '0, rect_y = '0, rect_w = '0, rect_h = '0;
    logic [SW-1:0] stride = '0;
    logic [1:0]    layout = '0;
    logic [2:0]    swz_mode = '0;
    logic          bpp32 = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [AW-1:0] out_index;
    logic          done;
    logic          cfg_err;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tile_addr_gen #(.COORD_W(CW), .STRIDE_W(SW), .ADDR_W(AW)) i_tile_addr_gen (
        .clk(clk), .rst_n(rst_n), .start(start),
        .rect_x(rect_x), .rect_y(rect_y), .rect_w(rect_w), .rect_h(rect_h),
        .stride(stride), .layout(layout), .swz_mode(swz_mode), .bpp32(bpp32),
        .out_valid(out_valid), .out_ready(out_ready), .out_index(out_index),
        .done(done), .cfg_err(cfg_err)
    );

    typedef struct packed {
        int lay; int swz; int b32; int strd; int x; int y; int w; int h; int rm;
    } vec_t;

    localparam vec_t TBL [9] = '{
        '{0, 0, 1,  400,   3,  2,  4, 3, 0},
        '{0, 3, 0,   64,   1,  5,  3, 2, 1},
        '{1, 0, 1, 1024, 126,  6,  4, 4, 0},
        '{1, 2, 0, 2048, 250,  7, 10, 3, 1},
        '{2, 0, 1,  256,   2, 30,  5, 4, 0},
        '{2, 4, 0,  512,  60,  3,  8, 2, 1},
        '{3, 0, 1,  256,  30,  2,  6, 4, 0},
        '{3, 0, 0,  384,   5, 12,  7, 6, 1},
        '{1, 1, 1,  512,   0,  0,  3, 2, 1}
    };

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Independent model written from the requirement text.
    function automatic longint ref_idx(int lay, int swz, int b32, int strd, int x, int y);
        longint ps, bx, pos, tpr, tn, ux, unit, base, tx, ty, sn, g, b9, b10, b11, f;
        ps = b32 ? 4 : 2;
        bx = x * ps;
        case (lay)
            1: begin
                tpr = strd / 512;
                tn  = (y / 8) * tpr + bx / 512;
                pos = tn * 4096 + (y % 8) * 512 + bx % 512;
            end
            2: begin
                ux   = bx / 16;
                tpr  = strd / 128;
                tn   = (y / 32) * tpr + ux / 8;
                unit = tn * 256 + (ux % 8) * 32 + y % 32;
                pos  = unit * 16 + bx % 16;
            end
            3: begin
                base = (y / 32) * strd * 32 + 4096 * (bx / 128);
                tx = bx % 128; ty = y % 32;
                sn = (ty / 4) * 8 + tx / 16;
                g  = (sn / 4) % 4;
                if (g == 1) sn = sn + 4;
                else if (g == 2) sn = sn - 4;
                pos = base + sn * 64 + (ty % 4) * 16 + tx % 16;
            end
            default: pos = y * strd + bx;
        endcase
        if (lay == 1 || lay == 2) begin
            b9 = (pos >> 9) & 1; b10 = (pos >> 10) & 1; b11 = (pos >> 11) & 1;
            case (swz)
                1: f = b9;
                2: f = b9 ^ b10;
                3: f = b9 ^ b11;
                4: f = b9 ^ b10 ^ b11;
                default: f = 0;
            endcase
            pos = pos ^ (f << 6);
        end
        return pos / ps;
    endfunction

    task automatic do_start(int lay, int swz, int b32, int strd, int x, int y, int w, int h);
        @(negedge clk);
        layout = 2'(lay); swz_mode = 3'(swz); bpp32 = 1'(b32); stride = SW'(strd);
        rect_x = CW'(x); rect_y = CW'(y); rect_w = CW'(w); rect_h = CW'(h);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic walk(string req, int lay, int swz, int b32, int strd,
                        int x, int y, int w, int h, int rm);
        int k = 0;
        int ex = x;
        int ey = y;
        int phase = 0;
        while (k < w * h) begin
            out_ready = (rm == 0) ? 1'b1 : ((phase % 3) != 0);
            phase++;
            #1;
            if (out_valid && out_ready) begin
                chk(req, out_index, ref_idx(lay, swz, b32, strd, ex, ey));
                k++;
                ex++;
                if (ex == x + w) begin
                    ex = x;
                    ey++;
                end
            end
            @(negedge clk);
        end
        out_ready = 1'b0;
        chk("R10 done after last", done, 1);
        chk("R2 no extra index", out_valid, 0);
        @(negedge clk);
        chk("R10 done one cycle", done, 0);
    endtask

    task automatic single(string req, int lay, int swz, int b32, int strd,
                          int x, int y, longint lit);
        do_start(lay, swz, b32, strd, x, y, 1, 1);
        chk("R2 not yet valid", out_valid, 0);
        @(negedge clk);
        chk("R2 first valid", out_valid, 1);
        chk(req, out_index, lit);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk("R10 single done", done, 1);
        @(negedge clk);
    endtask

    task automatic refuse(string req, int lay, int swz, int strd);
        do_start(lay, swz, 1, strd, 0, 0, 2, 2);
        chk(req, cfg_err, 1);
        chk("R8 no index", out_valid, 0);
        @(negedge clk);
        chk("R8 err one cycle", cfg_err, 0);
        chk("R8 no done", done, 0);
        @(negedge clk);
        chk("R8 still idle", out_valid, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        longint held;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", out_valid, 0);
        chk("R1 done in reset", done, 0);
        chk("R1 err in reset", cfg_err, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", out_valid, 0);
        chk("R1 done after reset", done, 0);

        // Table walk over layouts, swizzles and pixel sizes.
        for (int i = 0; i < 9; i++) begin
            string req;
            case (TBL[i].lay)
                1: req = "R4 R7 R12";
                2: req = "R5 R7 R12";
                3: req = "R6 R12";
                default: req = "R3 R7 R12";
            endcase
            do_start(TBL[i].lay, TBL[i].swz, TBL[i].b32, TBL[i].strd,
                     TBL[i].x, TBL[i].y, TBL[i].w, TBL[i].h);
            walk(req, TBL[i].lay, TBL[i].swz, TBL[i].b32, TBL[i].strd,
                 TBL[i].x, TBL[i].y, TBL[i].w, TBL[i].h, TBL[i].rm);
        end

        // Hand-computed anchors.
        single("R4 wide tile anchor", 1, 0, 1, 1024, 130, 9, 3202);
        single("R6 subtile remap anchor", 3, 0, 1, 256, 4, 4, 80);
        single("R7 swizzle bit9 anchor", 2, 1, 0, 128, 8, 0, 288);

        // Stall holds the index.
        do_start(1, 0, 1, 512, 127, 0, 2, 1);
        @(negedge clk);
        held = out_index;
        repeat (3) begin
            @(negedge clk);
            chk("R9 valid held", out_valid, 1);
            chk("R9 index held", out_index, held);
        end
        walk("R9 after stall", 1, 0, 1, 512, 127, 0, 2, 1, 0);

        // Start during a walk is ignored.
        do_start(0, 0, 1, 64, 0, 1, 3, 1);
        layout = 2'd1; rect_x = CW'(50); rect_w = CW'(9); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        walk("R11 stream unchanged", 0, 0, 1, 64, 0, 1, 3, 1, 1);
        repeat (2) @(negedge clk);
        chk("R11 no restart", out_valid, 0);

        // Empty rectangle.
        do_start(0, 0, 1, 64, 0, 0, 0, 4);
        chk("R10 empty done", done, 1);
        chk("R10 empty no index", out_valid, 0);
        @(negedge clk);
        chk("R10 empty done one cycle", done, 0);
        chk("R10 empty stays idle", out_valid, 0);

        // Refused configurations.
        refuse("R8 bad swizzle code", 1, 6, 512);
        refuse("R8 subtile with swizzle", 3, 1, 256);
        refuse("R8 wide stride misaligned", 1, 0, 768);
        refuse("R8 narrow stride misaligned", 2, 0, 200);

        // Recovery after a refusal.
        do_start(2, 3, 1, 256, 33, 31, 3, 2);
        walk("R5 R7 after refusal", 2, 3, 1, 256, 33, 31, 3, 2, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule